// File: doc/BRIEF.md
# Virtually-Indexed Physically-Tagged L1 Load Lookup

This block is the load lookup path of a level-one data cache whose sets are chosen from virtual address bits and whose tags hold physical page numbers. An accepted load uses only bits inside the 4 KiB page offset to pick its set. The array read of all ways and the translation lookaside buffer (TLB) lookup therefore start in the same cycle. One cycle later the translated page number is compared against every way's stored tag. On a match the selected bytes come out. On a mismatch a fill request leaves with the full physical address and a victim way.

With the default geometry (32 KiB, 8 ways, 64-byte lines, 64 sets) the set index is VA[11:6] and the line offset is VA[5:0]. If the TLB cannot translate the page, everything read for that access is thrown away and a walk is requested. The access is held inside the block and issued again from the start once the walker signals that the translation is ready. A simple line-install port writes a tag and a full line into a chosen way. It stands in for the refill path so that lines can be made resident.

Top module: `vipt_l1_lookup`

## Requirements
- R1: While a request is accepted (`req_valid` and `req_ready` high), `tlb_lookup` is high and `tlb_vpn` equals VA[31:12] in that same cycle. The set is chosen by VA[11:6] alone, so two virtual pages that map to the same physical page hit the same line.
- R2: The outcome of an accepted load (`resp_valid`, `miss_valid` or `walk_req`) appears exactly one cycle after acceptance and lasts one cycle.
- R3: When the TLB hits and a valid way in the set holds a tag equal to `tlb_ppn`, `resp_valid` and `resp_hit` are high and `miss_valid` is low.
- R4: `req_size` codes 0, 1, 2 and 3 select 1, 2, 4 and 8 bytes. The bytes start at line offset VA[5:0], are assembled little-endian into `resp_data` and are zero-extended.
- R5: A load whose VA[2:0] is not a multiple of its size returns `resp_valid` and `resp_err` with `resp_hit` low. It raises neither a miss nor a walk and leaves the replacement state unchanged.
- R6: When the TLB hits but no valid way matches, `miss_valid` is high and `miss_paddr` equals {`tlb_ppn`, VA[11:0]}; `resp_valid` stays low.
- R7: The victim way `miss_way` is the lowest-numbered invalid way of the set. If every way is valid, it is the way chosen by the tree pseudo-LRU.
- R8: The tree pseudo-LRU has 7 bits per set and points away from the most recently touched way. A hit touches the hitting way and a line install touches the installed way. The tree starts at zero, and a zero node bit points to the lower half.
- R9: On a TLB miss, `walk_req` pulses with `walk_vpn` = VA[31:12] and no response or miss is produced. `req_ready` then stays low until `xlat_ready`. In that cycle the held load is issued again (`tlb_lookup` high, same VPN), and its result appears one cycle later.
- R10: After reset every way is invalid, `req_ready` is high, and `resp_valid`, `miss_valid` and `walk_req` are low.
- R11: A pulse on `fill_valid` writes `fill_tag` and `fill_line` into way `fill_way` of set `fill_set` and marks that way valid. A later load that translates to that tag hits it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Load request present |
| req_ready | output | 1 | Block accepts a request this cycle |
| req_vaddr | input | 32 | Virtual address of the load |
| req_size | input | 2 | Size code: 0=1B, 1=2B, 2=4B, 3=8B |
| tlb_lookup | output | 1 | TLB lookup issued this cycle |
| tlb_vpn | output | 20 | Virtual page number to translate |
| tlb_hit | input | 1 | TLB result for the access in stage 2 |
| tlb_ppn | input | 24 | Physical page number for the access in stage 2 |
| walk_req | output | 1 | Translation missing, walk needed |
| walk_vpn | output | 20 | Page number that needs a walk |
| xlat_ready | input | 1 | Translation now available, replay the held load |
| fill_valid | input | 1 | Install a line |
| fill_set | input | 6 | Set to install into |
| fill_way | input | 3 | Way to install into |
| fill_tag | input | 24 | Physical tag of the installed line |
| fill_line | input | 512 | Line contents, byte 0 in bits 7:0 |
| resp_valid | output | 1 | Load completed (hit or error) |
| resp_hit | output | 1 | Completed with data |
| resp_err | output | 1 | Misaligned load |
| resp_data | output | 64 | Zero-extended load data |
| miss_valid | output | 1 | Cache miss, fill request |
| miss_paddr | output | 36 | Full physical address of the missing load |
| miss_way | output | 3 | Victim way for the fill |

## Verification
The hardest state to reach from the ports is a full set with a known pseudo-LRU tree. It is the only place where the replacement order itself is observable. The bench installs all eight ways of one set in a fixed order and then forces a tag mismatch to read the victim. Next it hits the reported victim, sends a misaligned load at another resident line, and misses again to see the victim move to the far subtree and stay there. A TLB miss followed by a delayed `xlat_ready` drives the block through discard and replay. Line contents that differ per set, way and byte show any wrong way or byte selection.

// File: rtl/vipt_pkg.sv
package vipt_pkg;

    typedef enum logic [1:0] {
        SZ_1B = 2'd0,
        SZ_2B = 2'd1,
        SZ_4B = 2'd2,
        SZ_8B = 2'd3
    } ld_size_e;

    typedef enum logic {
        MODE_RUN  = 1'b0,
        MODE_WAIT = 1'b1
    } mode_e;

endpackage

// File: rtl/vipt_way_bank.sv
module vipt_way_bank #(
    parameter int IDX_W  = 6,
    parameter int TAG_W  = 24,
    parameter int LINE_W = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [LINE_W-1:0] wr_line,
    output logic              rd_vld,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [LINE_W-1:0] rd_line
);
    localparam int NSETS = 1 << IDX_W;

    logic [TAG_W-1:0]  tag_mem  [NSETS];
    logic [LINE_W-1:0] line_mem [NSETS];
    logic [NSETS-1:0]  vld_q, vld_d;

    // tag and line storage: no reset, synchronous read
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx]  <= wr_tag;
            line_mem[wr_idx] <= wr_line;
        end
        if (rd_en) begin
            rd_tag  <= tag_mem[rd_idx];
            rd_line <= line_mem[rd_idx];
        end
    end

    always_comb begin
        vld_d = vld_q;
        if (wr_en) vld_d[wr_idx] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q  <= '0;
            rd_vld <= 1'b0;
        end else begin
            vld_q <= vld_d;
            if (rd_en) rd_vld <= vld_q[rd_idx];
        end
    end
endmodule

// File: rtl/vipt_plru.sv
module vipt_plru #(
    parameter int NSETS = 64,
    parameter int NWAYS = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(NSETS)-1:0] rd_set,
    output logic [$clog2(NWAYS)-1:0] lru_way,
    input  logic                     hit_en,
    input  logic [$clog2(NSETS)-1:0] hit_set,
    input  logic [$clog2(NWAYS)-1:0] hit_way,
    input  logic                     ins_en,
    input  logic [$clog2(NSETS)-1:0] ins_set,
    input  logic [$clog2(NWAYS)-1:0] ins_way
);
    localparam int WAY_W = $clog2(NWAYS);
    localparam int NODES = NWAYS - 1;
    localparam int NIW   = (NWAYS > 2) ? $clog2(NODES) : 1;

    logic [NODES-1:0] tree_q [NSETS];
    logic [NODES-1:0] tree_d [NSETS];

    // mark a way most recent: each node on its path points to the other half
    function automatic logic [NODES-1:0] touch(input logic [NODES-1:0] t,
                                               input logic [WAY_W-1:0] w);
        logic [NODES-1:0] r;
        int node;
        r = t;
        node = 0;
        for (int l = 0; l < WAY_W; l++) begin
            r[NIW'(node)] = ~w[WAY_W-1-l];
            node = 2 * node + 1 + int'(w[WAY_W-1-l]);
        end
        return r;
    endfunction

    // follow node bits from the root to the least recent leaf
    function automatic logic [WAY_W-1:0] follow(input logic [NODES-1:0] t);
        logic [WAY_W-1:0] w;
        int node;
        logic b;
        w = '0;
        node = 0;
        for (int l = 0; l < WAY_W; l++) begin
            b = t[NIW'(node)];
            w[WAY_W-1-l] = b;
            node = 2 * node + 1 + int'(b);
        end
        return w;
    endfunction

    assign lru_way = follow(tree_q[rd_set]);

    always_comb begin
        for (int s = 0; s < NSETS; s++) tree_d[s] = tree_q[s];
        if (hit_en) tree_d[hit_set] = touch(tree_q[hit_set], hit_way);
        if (ins_en) tree_d[ins_set] = touch(tree_d[ins_set], ins_way);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < NSETS; s++) tree_q[s] <= '0;
        end else begin
            for (int s = 0; s < NSETS; s++) tree_q[s] <= tree_d[s];
        end
    end
endmodule

// File: rtl/vipt_extract.sv
module vipt_extract #(
    parameter int LINE_BYTES = 64,
    parameter int OUT_BYTES  = 8
) (
    input  logic [LINE_BYTES*8-1:0]       line,
    input  logic [$clog2(LINE_BYTES)-1:0] offset,
    input  logic [1:0]                    size,
    output logic [OUT_BYTES*8-1:0]        data
);
    logic [LINE_BYTES*8-1:0] shifted;
    int nbytes;

    always_comb begin
        shifted = line >> {offset, 3'b000};
        nbytes  = 1 << size;
        for (int i = 0; i < OUT_BYTES; i++) begin
            data[8*i +: 8] = (i < nbytes) ? shifted[8*i +: 8] : 8'h00;
        end
    end
endmodule

// File: rtl/vipt_l1_lookup.sv
module vipt_l1_lookup
    import vipt_pkg::*;
#(
    parameter int VA_W       = 32,
    parameter int PA_W       = 36,
    parameter int PAGE_BITS  = 12,
    parameter int LINE_BYTES = 64,
    parameter int NWAYS      = 8,
    parameter int NSETS      = 64,
    parameter int DATA_BYTES = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic [VA_W-1:0]               req_vaddr,
    input  logic [1:0]                    req_size,
    output logic                          tlb_lookup,
    output logic [VA_W-PAGE_BITS-1:0]     tlb_vpn,
    input  logic                          tlb_hit,
    input  logic [PA_W-PAGE_BITS-1:0]     tlb_ppn,
    output logic                          walk_req,
    output logic [VA_W-PAGE_BITS-1:0]     walk_vpn,
    input  logic                          xlat_ready,
    input  logic                          fill_valid,
    input  logic [$clog2(NSETS)-1:0]      fill_set,
    input  logic [$clog2(NWAYS)-1:0]      fill_way,
    input  logic [PA_W-PAGE_BITS-1:0]     fill_tag,
    input  logic [LINE_BYTES*8-1:0]       fill_line,
    output logic                          resp_valid,
    output logic                          resp_hit,
    output logic                          resp_err,
    output logic [DATA_BYTES*8-1:0]       resp_data,
    output logic                          miss_valid,
    output logic [PA_W-1:0]               miss_paddr,
    output logic [$clog2(NWAYS)-1:0]      miss_way
);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int IDX_W  = $clog2(NSETS);
    localparam int WAY_W  = $clog2(NWAYS);
    localparam int TAG_W  = PA_W - PAGE_BITS;
    localparam int LINE_W = LINE_BYTES * 8;
    localparam int DATA_W = DATA_BYTES * 8;
    localparam int ALN_W  = $clog2(DATA_BYTES);

    typedef struct packed {
        logic            s2_vld;
        logic [VA_W-1:0] s2_va;
        logic [1:0]      s2_size;
        logic            s2_err;
        mode_e           mode;
        logic [VA_W-1:0] hold_va;
        logic [1:0]      hold_size;
    } pipe_t;

    pipe_t cur_q, nxt_d;

    logic            s2_lookup, xlat_miss, replay, issue, misalign;
    logic [VA_W-1:0] iss_va;
    logic [1:0]      iss_size;
    logic [ALN_W-1:0] aln_mask;

    // stage 1: accept or replay, read the set, start translation
    always_comb begin
        nxt_d     = cur_q;
        s2_lookup = cur_q.s2_vld && !cur_q.s2_err;
        xlat_miss = s2_lookup && !tlb_hit;
        req_ready = (cur_q.mode == MODE_RUN) && !xlat_miss;
        replay    = (cur_q.mode == MODE_WAIT) && xlat_ready;
        issue     = (req_valid && req_ready) || replay;
        iss_va    = replay ? cur_q.hold_va   : req_vaddr;
        iss_size  = replay ? cur_q.hold_size : req_size;
        aln_mask  = ALN_W'((1 << iss_size) - 1);
        misalign  = |(iss_va[ALN_W-1:0] & aln_mask);

        nxt_d.s2_vld = issue;
        if (issue) begin
            nxt_d.s2_va   = iss_va;
            nxt_d.s2_size = iss_size;
            nxt_d.s2_err  = misalign;
        end
        if (xlat_miss) begin
            nxt_d.mode      = MODE_WAIT;
            nxt_d.hold_va   = cur_q.s2_va;
            nxt_d.hold_size = cur_q.s2_size;
        end
        if (replay) nxt_d.mode = MODE_RUN;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{s2_vld: 1'b0, s2_va: '0, s2_size: 2'd0, s2_err: 1'b0,
                       mode: MODE_RUN, hold_va: '0, hold_size: 2'd0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign tlb_lookup = issue;
    assign tlb_vpn    = iss_va[VA_W-1:PAGE_BITS];

    // way banks: every way of the set is read in the same cycle
    logic [NWAYS-1:0]  rd_vld;
    logic [TAG_W-1:0]  rd_tag  [NWAYS];
    logic [LINE_W-1:0] rd_line [NWAYS];

    for (genvar w = 0; w < NWAYS; w++) begin : g_way
        vipt_way_bank #(.IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .rd_en  (issue),
            .rd_idx (iss_va[OFF_W +: IDX_W]),
            .wr_en  (fill_valid && (fill_way == WAY_W'(w))),
            .wr_idx (fill_set),
            .wr_tag (fill_tag),
            .wr_line(fill_line),
            .rd_vld (rd_vld[w]),
            .rd_tag (rd_tag[w]),
            .rd_line(rd_line[w])
        );
    end

    // stage 2: compare with the translated tag, select way and bytes
    logic [NWAYS-1:0]  hit_vec;
    logic              any_hit, do_hit;
    logic [WAY_W-1:0]  hit_way, lru_way, victim;
    logic [LINE_W-1:0] sel_line;
    logic [DATA_W-1:0] ext_data;
    logic              has_free;

    always_comb begin
        sel_line = '0;
        hit_way  = '0;
        for (int w = 0; w < NWAYS; w++) begin
            hit_vec[w] = rd_vld[w] && (rd_tag[w] == tlb_ppn);
            if (hit_vec[w]) begin
                sel_line = sel_line | rd_line[w];
                hit_way  = WAY_W'(w);
            end
        end
        any_hit = |hit_vec;
        do_hit  = s2_lookup && tlb_hit && any_hit;

        has_free = 1'b0;
        victim   = lru_way;
        for (int w = NWAYS - 1; w >= 0; w--) begin
            if (!rd_vld[w]) begin
                has_free = 1'b1;
                victim   = WAY_W'(w);
            end
        end
    end

    vipt_plru #(.NSETS(NSETS), .NWAYS(NWAYS)) u_plru (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_set (cur_q.s2_va[OFF_W +: IDX_W]),
        .lru_way(lru_way),
        .hit_en (do_hit),
        .hit_set(cur_q.s2_va[OFF_W +: IDX_W]),
        .hit_way(hit_way),
        .ins_en (fill_valid),
        .ins_set(fill_set),
        .ins_way(fill_way)
    );

    vipt_extract #(.LINE_BYTES(LINE_BYTES), .OUT_BYTES(DATA_BYTES)) u_ext (
        .line  (sel_line),
        .offset(cur_q.s2_va[OFF_W-1:0]),
        .size  (cur_q.s2_size),
        .data  (ext_data)
    );

    assign resp_err   = cur_q.s2_vld && cur_q.s2_err;
    assign resp_hit   = do_hit;
    assign resp_valid = resp_err || do_hit;
    assign resp_data  = do_hit ? ext_data : '0;
    assign miss_valid = s2_lookup && tlb_hit && !any_hit;
    assign miss_paddr = {tlb_ppn, cur_q.s2_va[PAGE_BITS-1:0]};
    assign miss_way   = has_free ? victim : lru_way;
    assign walk_req   = xlat_miss;
    assign walk_vpn   = cur_q.s2_va[VA_W-1:PAGE_BITS];
endmodule

// File: rtl/vipt_l1_lookup_chk.sv
module vipt_l1_lookup_chk (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic tlb_lookup,
    input logic walk_req,
    input logic xlat_ready,
    input logic resp_valid,
    input logic resp_hit,
    input logic resp_err,
    input logic miss_valid
);
    // R2
    out_follows_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid || miss_valid || walk_req) |-> $past(tlb_lookup));

    // R3
    hit_is_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_hit |-> (resp_valid && !resp_err && !miss_valid));

    // R5
    err_is_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_err |-> (!miss_valid && !walk_req && !resp_hit));

    // R6
    miss_not_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss_valid |-> !resp_valid);

    // R9
    walk_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req |=> (!req_ready && !resp_valid && !miss_valid && !walk_req));

    // R9
    wait_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !walk_req && !xlat_ready) |=> !req_ready);

    // R9
    ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_ready) |-> walk_req);
endmodule

bind vipt_l1_lookup vipt_l1_lookup_chk u_chk (.*);

// File: tb/sim_vipt_l1_lookup.sv
module sim_vipt_l1_lookup;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [31:0]  req_vaddr = '0;
    logic [1:0]   req_size = '0;
    logic         tlb_lookup;
    logic [19:0]  tlb_vpn;
    logic         tlb_hit = 1'b1;
    logic [23:0]  tlb_ppn = '0;
    logic         walk_req;
    logic [19:0]  walk_vpn;
    logic         xlat_ready = 1'b0;
    logic         fill_valid = 1'b0;
    logic [5:0]   fill_set = '0;
    logic [2:0]   fill_way = '0;
    logic [23:0]  fill_tag = '0;
    logic [511:0] fill_line = '0;
    logic         resp_valid, resp_hit, resp_err, miss_valid;
    logic [63:0]  resp_data;
    logic [35:0]  miss_paddr;
    logic [2:0]   miss_way;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    vipt_l1_lookup u0 (.*);

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int set, input int way, input int b);
        return 8'((set * 13 + way * 37 + b * 5 + 1) & 255);
    endfunction

    function automatic logic [511:0] mk_line(input int set, input int way);
        logic [511:0] l;
        for (int b = 0; b < 64; b++) l[8*b +: 8] = pat(set, way, b);
        return l;
    endfunction

    function automatic logic [63:0] exp_ld(input int set, input int way,
                                           input int off, input int sz);
        logic [63:0] r;
        r = '0;
        for (int i = 0; i < (1 << sz); i++) r[8*i +: 8] = pat(set, way, off + i);
        return r;
    endfunction

    function automatic logic [31:0] mk_va(input logic [19:0] vpn, input int set, input int off);
        return {vpn, 6'(set), 6'(off)};
    endfunction

    task automatic install(input int set, input int way, input logic [23:0] tag);
        @(negedge clk);
        fill_valid = 1'b1;
        fill_set   = 6'(set);
        fill_way   = 3'(way);
        fill_tag   = tag;
        fill_line  = mk_line(set, way);
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    // drive one load; outputs are left in place for the stage-2 cycle
    logic        s_lk, s_pre;
    logic [19:0] s_vpn;
    task automatic load(input logic [31:0] va, input logic [1:0] sz);
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = va;
        req_size  = sz;
        #1;
        s_lk  = tlb_lookup;
        s_vpn = tlb_vpn;
        s_pre = resp_valid | miss_valid;
        @(negedge clk);
        req_valid = 1'b0;
        #0.5;
    endtask

    task automatic t_reset();
        chk("R10", "req_ready", 64'(req_ready), 64'd1);
        chk("R10", "resp_valid", 64'(resp_valid), 64'd0);
        chk("R10", "miss_valid", 64'(miss_valid), 64'd0);
        chk("R10", "walk_req", 64'(walk_req), 64'd0);
    endtask

    task automatic t_cold_miss();
        tlb_hit = 1'b1;
        tlb_ppn = 24'hABCDE;
        load(mk_va(20'h12345, 5, 6'h10), 2'd3);
        chk("R1", "tlb_lookup at accept", 64'(s_lk), 64'd1);
        chk("R1", "tlb_vpn at accept", 64'(s_vpn), 64'h12345);
        chk("R2", "no outcome in accept cycle", 64'(s_pre), 64'd0);
        chk("R6", "miss_valid", 64'(miss_valid), 64'd1);
        chk("R6", "resp_valid on miss", 64'(resp_valid), 64'd0);
        chk("R6", "miss_paddr", 64'(miss_paddr), 64'h0ABCDE150);
        chk("R7", "victim empty set", 64'(miss_way), 64'd0);
        @(negedge clk);
        chk("R2", "outcome one cycle only", 64'(miss_valid), 64'd0);
    endtask

    task automatic t_fill_hit();
        install(5, 0, 24'hABCDE);
        tlb_ppn = 24'hABCDE;
        // different virtual page, same set bits, same physical page
        load(mk_va(20'h07777, 5, 6'h3F), 2'd0);
        chk("R11", "hit after install", 64'(resp_hit), 64'd1);
        chk("R4", "1B at 0x3F", resp_data, exp_ld(5, 0, 63, 0));
        load(mk_va(20'h07777, 5, 6'h3E), 2'd1);
        chk("R4", "2B at 0x3E", resp_data, exp_ld(5, 0, 62, 1));
        load(mk_va(20'h00001, 5, 6'h3C), 2'd2);
        chk("R4", "4B at 0x3C", resp_data, exp_ld(5, 0, 60, 2));
        load(mk_va(20'h12345, 5, 6'h08), 2'd3);
        chk("R3", "resp_valid on hit", 64'(resp_valid), 64'd1);
        chk("R3", "miss_valid on hit", 64'(miss_valid), 64'd0);
        chk("R4", "8B at 0x08", resp_data, exp_ld(5, 0, 8, 3));
    endtask

    task automatic t_tag_mismatch();
        tlb_ppn = 24'h11111;
        load(mk_va(20'h12345, 5, 6'h20), 2'd2);
        chk("R3", "no hit on other tag", 64'(resp_hit), 64'd0);
        chk("R6", "miss on other tag", 64'(miss_valid), 64'd1);
        chk("R7", "lowest invalid victim", 64'(miss_way), 64'd1);
    endtask

    task automatic t_misalign();
        tlb_ppn = 24'hABCDE;
        load(mk_va(20'h12345, 5, 6'h03), 2'd2);
        chk("R5", "resp_err", 64'(resp_err), 64'd1);
        chk("R5", "resp_valid", 64'(resp_valid), 64'd1);
        chk("R5", "no hit", 64'(resp_hit), 64'd0);
        chk("R5", "no miss", 64'(miss_valid), 64'd0);
        chk("R5", "no walk", 64'(walk_req), 64'd0);
    endtask

    task automatic t_tlb_miss();
        tlb_hit = 1'b0;
        tlb_ppn = 24'h0;
        load(mk_va(20'h5A5A5, 5, 6'h18), 2'd3);
        chk("R9", "walk_req", 64'(walk_req), 64'd1);
        chk("R9", "walk_vpn", 64'(walk_vpn), 64'h5A5A5);
        chk("R9", "no response", 64'(resp_valid | miss_valid), 64'd0);
        chk("R9", "ready low at miss", 64'(req_ready), 64'd0);
        repeat (3) @(negedge clk);
        chk("R9", "ready low while waiting", 64'(req_ready), 64'd0);
        tlb_hit    = 1'b1;
        tlb_ppn    = 24'hABCDE;
        xlat_ready = 1'b1;
        #1;
        chk("R9", "replay lookup", 64'(tlb_lookup), 64'd1);
        chk("R9", "replay vpn", 64'(tlb_vpn), 64'h5A5A5);
        @(negedge clk);
        xlat_ready = 1'b0;
        #0.5;
        chk("R9", "replayed hit", 64'(resp_hit), 64'd1);
        chk("R9", "replayed data", resp_data, exp_ld(5, 0, 24, 3));
        chk("R9", "ready back", 64'(req_ready), 64'd1);
    endtask

    task automatic t_plru();
        for (int w = 0; w < 8; w++) install(9, w, 24'h200 + 24'(w));
        tlb_ppn = 24'h999;
        load(mk_va(20'h00042, 9, 0), 2'd0);
        chk("R8", "victim after in-order installs", 64'(miss_way), 64'd0);
        tlb_ppn = 24'h200;
        load(mk_va(20'h00042, 9, 6'h10), 2'd2);
        chk("R3", "hit way 0 of full set", resp_data, exp_ld(9, 0, 16, 2));
        tlb_ppn = 24'h203;
        load(mk_va(20'h00042, 9, 6'h21), 2'd1);
        chk("R5", "misaligned on resident line", 64'(resp_err), 64'd1);
        tlb_ppn = 24'h999;
        load(mk_va(20'h00042, 9, 0), 2'd0);
        chk("R8", "victim moves after hit", 64'(miss_way), 64'd4);
        chk("R7", "full set uses tree", 64'(miss_valid), 64'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cold_miss();
        t_fill_hit();
        t_tag_mismatch();
        t_misalign();
        t_tlb_miss();
        t_plru();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL R2 watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule